// File: doc/BRIEF.md
# Cipher Half-Round Mixing Datapath

This block forms the data-dependent core of one encryption round of a block cipher that works on four 32-bit words. Two quadratic units each take one word and compute `(2*X*X + X) mod 2^32`, then rotate the result left by a fixed 5. The value taken from word B masks word A and sets the rotate amount for word C. The value taken from word D masks word C and sets the rotate amount for word A. Each masked word passes through a 5-bit-amount barrel rotator, and a round key is then added modulo 2^32.

The results are rotated one place through the four word positions so that the next round can be fed straight back in. A register stage captures all four new words on a clock enable. Key expansion, whitening and round counting belong to the surrounding logic.

Top module: `half_round_reg`

## Requirements
- R1: The mask derived from B is t = rotl((2*B*B + B) mod 2^32, 5), and the mask derived from D is u, formed the same way from D. For example, B = 0xFF123123 gives t = 0xF8E0D6AA.
- R2: The new A word is ((A xor t) rotated left by u[4:0]) + key_even, with the sum taken mod 2^32.
- R3: The new C word is ((C xor u) rotated left by t[4:0]) + key_odd, with the sum taken mod 2^32.
- R4: A variable rotate by k (0..31) moves input bit i to bit (i+k) mod 32. For example, 0x0000FFFF rotated by 2 gives 0x0003FFFC, and rotated by 16 gives 0xFFFF0000.
- R5: A rotate amount of zero passes the masked word through unchanged.
- R6: The words leave in permuted order: a_out = B, b_out = new C, c_out = D, d_out = new A.
- R7: While load_en is low, all four outputs hold their values, whatever the data inputs do.
- R8: A high rst at a rising edge clears all four outputs to zero, and it takes priority over load_en.
- R9: When load_en is high at a rising edge, the results computed from the inputs present at that edge appear on the outputs just after it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous reset, active high |
| load_en | input | 1 | Capture enable for the output words |
| a_in | input | 32 | Data word A |
| b_in | input | 32 | Data word B, the source of mask t |
| c_in | input | 32 | Data word C |
| d_in | input | 32 | Data word D, the source of mask u |
| key_even | input | 32 | Round key added to the new A |
| key_odd | input | 32 | Round key added to the new C |
| a_out | output | 32 | Registered B |
| b_out | output | 32 | Registered new C |
| c_out | output | 32 | Registered D |
| d_out | output | 32 | Registered new A |

## Verification
The arithmetic is purely combinational, so every result is due one clock edge after the edge at which load_en is sampled high. The bench changes inputs and enables on the falling edge and reads the outputs on the next falling edge. That places each read half a period after the capturing rising edge. For the hold and reset cases, the reads fall one and two edges after the stimulus changes, so a stray capture would be seen.

// File: rtl/hrmix_pkg.sv
package hrmix_pkg;
  localparam int unsigned WORD_W = 32;
  localparam int unsigned AMT_W  = $clog2(WORD_W);
  localparam int unsigned QROT   = AMT_W;   // fixed rotate of the quadratic unit

  typedef logic [WORD_W-1:0] word_t;
  typedef logic [AMT_W-1:0]  amt_t;

  // Rotate left by a constant n, 0 < n < WORD_W.
  function automatic word_t rotl_const(input word_t x, input int unsigned n);
    return (x << n) | (x >> (WORD_W - n));
  endfunction

  // (2*x*x + x) mod 2^WORD_W; only the low half of the square is ever needed.
  function automatic word_t quad_poly(input word_t x);
    word_t sq;
    sq = x * x;
    return (sq << 1) + x;
  endfunction
endpackage

// File: rtl/quad_rot_unit.sv
module quad_rot_unit
  import hrmix_pkg::*;
(
  input  word_t x_i,
  output word_t poly_o,
  output word_t y_o
);
  assign poly_o = quad_poly(x_i);
  assign y_o    = rotl_const(poly_o, QROT);
endmodule

// File: rtl/barrel_rotl.sv
module barrel_rotl
  import hrmix_pkg::*;
#(
  parameter int unsigned STAGES = AMT_W
) (
  input  word_t            din,
  input  logic [STAGES-1:0] amt,
  output word_t            dout
);
  word_t lvl [0:STAGES];

  assign lvl[0] = din;

  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    localparam int unsigned DIST = 1 << g;
    assign lvl[g+1] = amt[g] ? rotl_const(lvl[g], DIST) : lvl[g];
  end

  assign dout = lvl[STAGES];
endmodule

// File: rtl/mix_core.sv
module mix_core
  import hrmix_pkg::*;
(
  input  word_t a_i,
  input  word_t b_i,
  input  word_t c_i,
  input  word_t d_i,
  input  word_t k_even_i,
  input  word_t k_odd_i,
  output word_t t_o,
  output word_t u_o,
  output word_t mask_a_o,
  output word_t mask_c_o,
  output word_t rot_a_o,
  output word_t rot_c_o,
  output word_t nxt_a_o,
  output word_t nxt_b_o,
  output word_t nxt_c_o,
  output word_t nxt_d_o
);
  word_t poly_b, poly_d;
  word_t new_a, new_c;

  quad_rot_unit u_quad_b (.x_i(b_i), .poly_o(poly_b), .y_o(t_o));
  quad_rot_unit u_quad_d (.x_i(d_i), .poly_o(poly_d), .y_o(u_o));

  assign mask_a_o = a_i ^ t_o;
  assign mask_c_o = c_i ^ u_o;

  // Cross-coupled amounts: u steers A, t steers C.
  barrel_rotl u_rot_a (.din(mask_a_o), .amt(u_o[AMT_W-1:0]), .dout(rot_a_o));
  barrel_rotl u_rot_c (.din(mask_c_o), .amt(t_o[AMT_W-1:0]), .dout(rot_c_o));

  assign new_a = rot_a_o + k_even_i;
  assign new_c = rot_c_o + k_odd_i;

  // Word rotation for the next round.
  assign nxt_a_o = b_i;
  assign nxt_b_o = new_c;
  assign nxt_c_o = d_i;
  assign nxt_d_o = new_a;
endmodule

// File: rtl/half_round_reg.sv
module half_round_reg
  import hrmix_pkg::*;
(
  input  logic                clk,
  input  logic                rst,
  input  logic                load_en,
  input  logic [WORD_W-1:0]   a_in,
  input  logic [WORD_W-1:0]   b_in,
  input  logic [WORD_W-1:0]   c_in,
  input  logic [WORD_W-1:0]   d_in,
  input  logic [WORD_W-1:0]   key_even,
  input  logic [WORD_W-1:0]   key_odd,
  output logic [WORD_W-1:0]   a_out,
  output logic [WORD_W-1:0]   b_out,
  output logic [WORD_W-1:0]   c_out,
  output logic [WORD_W-1:0]   d_out
);
  word_t t_w, u_w, mask_a_w, mask_c_w, rot_a_w, rot_c_w;
  word_t nxt_a, nxt_b, nxt_c, nxt_d;

  mix_core u_core (
    .a_i(a_in), .b_i(b_in), .c_i(c_in), .d_i(d_in),
    .k_even_i(key_even), .k_odd_i(key_odd),
    .t_o(t_w), .u_o(u_w),
    .mask_a_o(mask_a_w), .mask_c_o(mask_c_w),
    .rot_a_o(rot_a_w), .rot_c_o(rot_c_w),
    .nxt_a_o(nxt_a), .nxt_b_o(nxt_b), .nxt_c_o(nxt_c), .nxt_d_o(nxt_d)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      a_out <= '0;
      b_out <= '0;
      c_out <= '0;
      d_out <= '0;
    end else if (load_en) begin
      a_out <= nxt_a;
      b_out <= nxt_b;
      c_out <= nxt_c;
      d_out <= nxt_d;
    end
  end

  // R8: reset clears and overrides the enable
  a_r8_reset_clear: assert property (@(posedge clk)
    rst |=> (a_out == '0 && b_out == '0 && c_out == '0 && d_out == '0));

  // R7: no capture without the enable
  a_r7_hold: assert property (@(posedge clk) disable iff (rst)
    !load_en |=> ($stable(a_out) && $stable(b_out) && $stable(c_out) && $stable(d_out)));

  // R6, R9: pass-through words land in their permuted slots one edge later
  a_r6_permute: assert property (@(posedge clk) disable iff (rst)
    load_en |=> (a_out == $past(b_in) && c_out == $past(d_in)));

  // R4: a rotate only moves bits, never creates or drops them
  a_r4_rot_ones_a: assert property (@(posedge clk) disable iff (rst)
    $countones(rot_a_w) == $countones(mask_a_w));
  a_r4_rot_ones_c: assert property (@(posedge clk) disable iff (rst)
    $countones(rot_c_w) == $countones(mask_c_w));

  // R5: zero amount is a pass-through
  a_r5_zero_amt_a: assert property (@(posedge clk) disable iff (rst)
    (u_w[AMT_W-1:0] == '0) |-> (rot_a_w == mask_a_w));
  a_r5_zero_amt_c: assert property (@(posedge clk) disable iff (rst)
    (t_w[AMT_W-1:0] == '0) |-> (rot_c_w == mask_c_w));
endmodule

// File: tb/tb_half_round_reg.sv
`timescale 1ns/1ps
module tb_half_round_reg;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        load_en = 1'b0;
  logic [31:0] a_in = '0, b_in = '0, c_in = '0, d_in = '0;
  logic [31:0] key_even = '0, key_odd = '0;
  logic [31:0] a_out, b_out, c_out, d_out;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  always #10 clk = ~clk;

  half_round_reg dut (
    .clk(clk), .rst(rst), .load_en(load_en),
    .a_in(a_in), .b_in(b_in), .c_in(c_in), .d_in(d_in),
    .key_even(key_even), .key_odd(key_odd),
    .a_out(a_out), .b_out(b_out), .c_out(c_out), .d_out(d_out)
  );

  function automatic logic [31:0] m_rot(input logic [31:0] x, input int k);
    logic [63:0] dbl;
    dbl = {x, x} << k;
    return dbl[63:32];
  endfunction

  function automatic logic [31:0] m_quad(input logic [31:0] x);
    logic [63:0] full;
    full = {32'd0, x} * {32'd0, x};
    return m_rot(full[31:0] + full[31:0] + x, 5);
  endfunction

  task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic drive(input logic [31:0] a, b, c, d, ke, ko);
    a_in = a; b_in = b; c_in = c; d_in = d; key_even = ke; key_odd = ko;
  endtask

  // Load one set and check all four outputs against the model.
  task automatic load_check(input logic [31:0] a, b, c, d, ke, ko);
    logic [31:0] t, u;
    @(negedge clk);
    drive(a, b, c, d, ke, ko);
    load_en = 1'b1;
    @(negedge clk);
    load_en = 1'b0;
    t = m_quad(b);
    u = m_quad(d);
    chk("R6 a_out", a_out, b);
    chk("R3 b_out", b_out, m_rot(c ^ u, int'(t[4:0])) + ko);
    chk("R6 c_out", c_out, d);
    chk("R2 d_out", d_out, m_rot(a ^ t, int'(u[4:0])) + ke);
  endtask

  initial begin
    #(200000 * 20);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h1234_5678));
    repeat (2) @(negedge clk);
    chk("R8 reset a", a_out, 32'h0); chk("R8 reset b", b_out, 32'h0);
    chk("R8 reset c", c_out, 32'h0); chk("R8 reset d", d_out, 32'h0);
    rst = 1'b0;

    // R1: with A = 0, D = 0 and zero keys, d_out equals t.
    load_check(0, 32'hFF123123, 0, 0, 0, 0); chk("R1 t", d_out, 32'hF8E0D6AA);
    load_check(0, 32'h897ABCDE, 0, 0, 0, 0); chk("R1 t", d_out, 32'hEB0BBCDB);
    load_check(0, 32'h00000020, 0, 0, 0, 0); chk("R1 t", d_out, 32'h00010400);
    // R5: t = 0x20 gives zero amount for C; u = 0 gives zero amount for A.
    load_check(32'h0, 32'hFFFFFFFF, 32'h0000FFFF, 0, 0, 0);
    chk("R5 c pass", b_out, 32'h0000FFFF); chk("R5 a pass", d_out, 32'h00000020);
    // R4: t[4:0] = 2 and 16.
    load_check(0, 32'h10000000, 32'h0000FFFF, 0, 0, 0); chk("R4 rot2", b_out, 32'h0003FFFC);
    load_check(0, 32'h80000001, 32'h0000FFFF, 0, 0, 0); chk("R4 rot16", b_out, 32'hFFFF0000);
    // R2/R3 key wrap
    load_check(32'hFFFFFFFF, 32'h99000099, 32'hFFFFFFFF, 32'hBCD2341C, 32'hFFFFFFFF, 32'hFFFFFFFF);

    // R9 / R2 / R3: random words and keys
    for (int i = 0; i < 60; i++)
      load_check($urandom, $urandom, $urandom, $urandom, $urandom, $urandom);

    // R7: inputs move, enable low, outputs unchanged
    begin
      logic [31:0] ha, hb, hc, hd;
      ha = a_out; hb = b_out; hc = c_out; hd = d_out;
      @(negedge clk);
      drive($urandom, $urandom, $urandom, $urandom, $urandom, $urandom);
      repeat (2) @(negedge clk);
      chk("R7 hold a", a_out, ha); chk("R7 hold b", b_out, hb);
      chk("R7 hold c", c_out, hc); chk("R7 hold d", d_out, hd);
    end

    // R8: reset wins over load_en
    @(negedge clk);
    rst = 1'b1; load_en = 1'b1;
    @(negedge clk);
    rst = 1'b0; load_en = 1'b0;
    chk("R8 prio a", a_out, 32'h0); chk("R8 prio b", b_out, 32'h0);
    chk("R8 prio c", c_out, 32'h0); chk("R8 prio d", d_out, 32'h0);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule